// File: doc/BRIEF.md
# UART Task/Event Register Controller

This block is the register-side control of a UART built around tasks and events. It sits between a 32-bit register bus and a byte-wide datapath, and leaves bit-level shifting, baud generation and pin routing to other logic. Software writes task registers to start or stop each direction. It observes hardware activity through sticky event flags, and it gets a single level interrupt through a per-event mask. A six-byte circular receive queue is drained by reading a data register. Transmit bytes leave through a valid/ready byte port, and received bytes enter through another one. A break indication on the line feeds an error-source register.

The whole peripheral sits behind a magic enable value. While it is off, reads return zero and only the enable register listens. Three state machines run it:

- **Control machine:** `CTL_OFF` goes to `CTL_ON` on a write of 4 to the enable register. `CTL_ON` goes back to `CTL_OFF` on a write of 0.
- **Receive machine:** `RX_HALT` goes to `RX_LISTEN` on a start-receive task. `RX_LISTEN` goes back to `RX_HALT` on stop-receive, suspend or disable.
- **Transmit machine:** it has four states:
  - `TX_HALT` goes to `TX_ARMED` on start-transmit.
  - `TX_ARMED` goes to `TX_SEND` when a byte is written, and to `TX_HALT` on a stop.
  - `TX_SEND` goes to `TX_ARMED` on handshake, to `TX_DRAIN` on a stop, and to `TX_HALT` on stop and handshake together.
  - `TX_DRAIN` goes to `TX_HALT` on handshake, to `TX_SEND` on start, and to `TX_ARMED` on start and handshake together.

A byte already handed over is therefore still delivered after a stop.

The register map uses byte offsets on a word-aligned bus, and each read returns data one cycle after the request. The event flags are interrupt bits 0 to 3:

| Offset | Register | Mask bit |
|---|---|---|
| 0x20 | receive-ready event | 0 |
| 0x24 | transmit-ready event | 1 |
| 0x28 | error event | 2 |
| 0x2C | receive-timeout event | 3 |

Top module: `uart_evt_ctrl`

## Requirements
- R1: `irq` is high exactly when some event flag and its mask bit are both set. The flags are receive-ready (bit 0, 0x20), transmit-ready (bit 1, 0x24), error (bit 2, 0x28) and receive-timeout (bit 3, 0x2C).
- R2: While disabled, every read returns zero one cycle after the request, and every write other than to the enable register (0x54) is ignored.
- R3: Writing 4 to 0x54 enables the block, and other nonzero values are ignored. Writing 0 disables it, stops both directions and sets the receive-timeout event. While enabled, 0x54 reads back 4.
- R4: A write to 0x40 loads the 4-bit mask, a write to 0x44 ORs bits into it, and a write to 0x48 clears the bits written as one. Reads of 0x40, 0x44 and 0x48 all return the mask.
- R5: The error-source register (0x50) clears the bits written as one. A `line_break` pulse sets its bits 1:0 and the error event.
- R6: A write to the transmit data register (0x64) is taken only when the transmitter is started and no byte is pending. The byte is then offered on `tx_data` with `tx_valid` until `tx_ready`. The handshake drops `tx_valid` and sets the transmit-ready event.
- R7: Writing 1 to stop-receive (0x04) halts the receiver and sets receive-timeout. Writing 1 to suspend (0x10) does the same and also halts the transmitter. Writing 1 to stop-transmit (0x0C) halts only the transmitter.
- R8: Writing 1 to start-receive (0x00) or start-transmit (0x08) starts that direction. Any other value has no effect.
- R9: Reading 0x60 returns the oldest queued byte. The queue advances only if the receiver is started and not empty, and if bytes remain after the pop the receive-ready event is set again.
- R10: `rx_ready` is high only while the receiver is started and fewer than 6 bytes are queued. Each accepted byte sets receive-ready, and that flag is cleared only by writing 0 to 0x20.
- R11: After reset the pin-select registers 0x70, 0x74, 0x78 and 0x7C read all ones and the baud register 0x80 reads 0x04000000. Every other register is zero and the block is disabled.
- R12: A write to the transmit-ready, error or receive-timeout event sets the flag when the value is nonzero and clears it when the value is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access request this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| tx_data | output | 8 | Byte offered to the transmitter |
| tx_valid | output | 1 | A transmit byte is pending |
| tx_ready | input | 1 | Transmitter takes the byte |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | Received byte present |
| rx_ready | output | 1 | Receive queue can take a byte |
| line_break | input | 1 | Break condition detected on the line |
| irq | output | 1 | Level interrupt |

## Verification
On every cycle the assertions check the following:
- Reads while disabled return zero, and mask writes while disabled leave the mask alone.
- Disabling halts reception and sets receive-timeout.
- A break sets both error indications.
- A pending transmit byte stays stable until taken.
- The queue never exceeds six entries and steps down by one on a pop.

Only the bench's scenarios can show the following:
- Data order through the circular queue across wrap-around.
- Bytes that are refused at a full queue.
- The interplay of stop, suspend and restart with buffered data.
- The full interrupt truth table over every mask and event combination.

// File: rtl/uart_evt_pkg.sv
package uart_evt_pkg;

    typedef enum logic [0:0] {CTL_OFF, CTL_ON} ctl_state_t;
    typedef enum logic [0:0] {RX_HALT, RX_LISTEN} rx_state_t;
    typedef enum logic [1:0] {TX_HALT, TX_ARMED, TX_SEND, TX_DRAIN} tx_state_t;

    localparam int REG_ADDR_W  = 8;
    localparam int NUM_EV      = 4;
    localparam int EV_RXRDY    = 0;
    localparam int EV_TXRDY    = 1;
    localparam int EV_ERR      = 2;
    localparam int EV_RXTMO    = 3;
    localparam int ERRSRC_W    = 4;
    localparam int ENABLE_KEY  = 4;

    // byte offsets of the register map
    localparam int OFS_START_RX = 'h00;
    localparam int OFS_STOP_RX  = 'h04;
    localparam int OFS_START_TX = 'h08;
    localparam int OFS_STOP_TX  = 'h0C;
    localparam int OFS_SUSPEND  = 'h10;
    localparam int OFS_EV_BASE  = 'h20;
    localparam int OFS_MASK     = 'h40;
    localparam int OFS_MASK_SET = 'h44;
    localparam int OFS_MASK_CLR = 'h48;
    localparam int OFS_ERRSRC   = 'h50;
    localparam int OFS_ENABLE   = 'h54;
    localparam int OFS_RXD      = 'h60;
    localparam int OFS_TXD      = 'h64;
    localparam int OFS_PIN_BASE = 'h70;
    localparam int OFS_BAUD     = 'h80;

    localparam logic [31:0] BAUD_RESET = 32'h0400_0000;

endpackage

// File: rtl/uart_evt_rxq.sv
module uart_evt_rxq
    import uart_evt_pkg::*;
#(
    parameter int DEPTH  = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              push_valid_i,
    input  logic [DATA_W-1:0] push_data_i,
    input  logic              pop_i,
    output logic              push_ready_o,
    output logic [DATA_W-1:0] head_data_o,
    output logic              pushed_o,
    output logic              popped_o,
    output logic              remain_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_C  = PTR_W'(DEPTH - 1);

    rx_state_t state_q, state_d;
    logic [PTR_W-1:0]  head_q, tail;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W:0]    tail_sum;
    logic [DATA_W-1:0] mem_q [DEPTH];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RX_HALT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_HALT:   if (start_i) state_d = RX_LISTEN;
            RX_LISTEN: if (stop_i)  state_d = RX_HALT;
        endcase
    end

    // outputs
    always_comb begin
        push_ready_o = (state_q == RX_LISTEN) && (cnt_q < DEPTH_C);
        pushed_o     = push_valid_i && push_ready_o;
        popped_o     = pop_i && (state_q == RX_LISTEN) && (cnt_q != '0);
        remain_o     = popped_o && (cnt_q > CNT_W'(1));
        head_data_o  = mem_q[head_q];
        tail_sum     = (CNT_W+1)'(head_q) + (CNT_W+1)'(cnt_q);
        tail         = (tail_sum >= (CNT_W+1)'(DEPTH)) ?
                       PTR_W'(tail_sum - (CNT_W+1)'(DEPTH)) : PTR_W'(tail_sum);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (popped_o) head_q <= (head_q == LAST_C) ? '0 : head_q + 1'b1;
            case ({pushed_o, popped_o})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_slot
            always_ff @(posedge clk) begin
                if (!rst_n)                             mem_q[i] <= '0;
                else if (pushed_o && tail == PTR_W'(i)) mem_q[i] <= push_data_i;
            end
        end
    endgenerate

    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= DEPTH_C);
    assert_pop_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (popped_o && !pushed_o) |=> cnt_q == $past(cnt_q) - 1'b1);
    assert_halt_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_HALT && pop_i) |=> $stable(head_q));

endmodule

// File: rtl/uart_evt_txfsm.sv
module uart_evt_txfsm
    import uart_evt_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              load_i,
    input  logic [DATA_W-1:0] load_data_i,
    input  logic              ready_i,
    output logic              valid_o,
    output logic [DATA_W-1:0] data_o,
    output logic              done_o
);
    tx_state_t state_q, state_d;
    logic accept;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TX_HALT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_HALT:  if (start_i) state_d = TX_ARMED;
            TX_ARMED: begin
                if (stop_i)      state_d = TX_HALT;
                else if (load_i) state_d = TX_SEND;
            end
            TX_SEND: begin
                if (stop_i && done_o) state_d = TX_HALT;
                else if (stop_i)      state_d = TX_DRAIN;
                else if (done_o)      state_d = TX_ARMED;
            end
            TX_DRAIN: begin
                if (start_i && done_o) state_d = TX_ARMED;
                else if (start_i)      state_d = TX_SEND;
                else if (done_o)       state_d = TX_HALT;
            end
        endcase
    end

    // outputs
    always_comb begin
        valid_o = (state_q == TX_SEND) || (state_q == TX_DRAIN);
        done_o  = valid_o && ready_i;
        accept  = (state_q == TX_ARMED) && load_i && !stop_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      data_o <= '0;
        else if (accept) data_o <= load_data_i;
    end

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i) |=> (valid_o && $stable(data_o)));
    assert_handoff_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && ready_i) |=> !valid_o);

endmodule

// File: rtl/uart_evt_ctrl.sv
module uart_evt_ctrl
    import uart_evt_pkg::*;
#(
    parameter int ADDR_W     = REG_ADDR_W,
    parameter int BUS_W      = 32,
    parameter int DATA_W     = 8,
    parameter int RXQ_DEPTH  = 6,
    parameter int NUM_PINSEL = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic              line_break,
    output logic              irq
);
    ctl_state_t ctl_q, ctl_d;
    logic on, wr_any, rd_any, wr_en, val_one, val_zero;
    logic go_on, go_off, rx_start, rx_stop, tx_start, tx_stop, tx_load, pop;
    logic rx_pushed, rx_popped, rx_remain, tx_done;
    logic [DATA_W-1:0]   rx_head;
    logic [NUM_EV-1:0]   ev_q, ev_d, mask_q;
    logic [ERRSRC_W-1:0] errsrc_q;
    logic [BUS_W-1:0]    baud_q, rd_mux;
    logic [BUS_W-1:0]    pinsel_q [NUM_PINSEL];

    function automatic logic hit(input int ofs);
        return bus_addr == ADDR_W'(ofs);
    endfunction

    // control state register
    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= CTL_OFF;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q)
            CTL_OFF: if (go_on)  ctl_d = CTL_ON;
            CTL_ON:  if (go_off) ctl_d = CTL_OFF;
        endcase
    end

    // control outputs and decoded strobes
    always_comb begin
        on       = (ctl_q == CTL_ON);
        wr_any   = bus_sel && bus_wr;
        rd_any   = bus_sel && !bus_wr;
        wr_en    = wr_any && on;
        val_one  = (bus_wdata == BUS_W'(1));
        val_zero = (bus_wdata == '0);
        go_on    = wr_any && hit(OFS_ENABLE) && (bus_wdata == BUS_W'(ENABLE_KEY));
        go_off   = wr_any && hit(OFS_ENABLE) && val_zero;
        rx_start = wr_en && hit(OFS_START_RX) && val_one;
        tx_start = wr_en && hit(OFS_START_TX) && val_one;
        rx_stop  = (wr_en && (hit(OFS_STOP_RX) || hit(OFS_SUSPEND)) && val_one) || go_off;
        tx_stop  = (wr_en && (hit(OFS_STOP_TX) || hit(OFS_SUSPEND)) && val_one) || go_off;
        tx_load  = wr_en && hit(OFS_TXD);
        pop      = rd_any && on && hit(OFS_RXD);
        irq      = |(ev_q & mask_q);
    end

    uart_evt_rxq #(.DEPTH(RXQ_DEPTH), .DATA_W(DATA_W)) u_rxq (
        .clk(clk), .rst_n(rst_n), .start_i(rx_start), .stop_i(rx_stop),
        .push_valid_i(rx_valid), .push_data_i(rx_data), .pop_i(pop),
        .push_ready_o(rx_ready), .head_data_o(rx_head),
        .pushed_o(rx_pushed), .popped_o(rx_popped), .remain_o(rx_remain)
    );

    uart_evt_txfsm #(.DATA_W(DATA_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .start_i(tx_start), .stop_i(tx_stop),
        .load_i(tx_load), .load_data_i(bus_wdata[DATA_W-1:0]),
        .ready_i(tx_ready), .valid_o(tx_valid), .data_o(tx_data), .done_o(tx_done)
    );

    // event flags: hardware set wins over a software write in the same cycle
    always_comb begin
        ev_d = ev_q;
        if (wr_en && hit(OFS_EV_BASE + 4*EV_RXRDY) && val_zero) ev_d[EV_RXRDY] = 1'b0;
        if (wr_en && hit(OFS_EV_BASE + 4*EV_TXRDY)) ev_d[EV_TXRDY] = !val_zero;
        if (wr_en && hit(OFS_EV_BASE + 4*EV_ERR))   ev_d[EV_ERR]   = !val_zero;
        if (wr_en && hit(OFS_EV_BASE + 4*EV_RXTMO)) ev_d[EV_RXTMO] = !val_zero;
        if (rx_pushed || rx_remain) ev_d[EV_RXRDY] = 1'b1;
        if (tx_done)                ev_d[EV_TXRDY] = 1'b1;
        if (line_break)             ev_d[EV_ERR]   = 1'b1;
        if (rx_stop)                ev_d[EV_RXTMO] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_q     <= '0;
            mask_q   <= '0;
            errsrc_q <= '0;
            baud_q   <= BAUD_RESET;
        end else begin
            ev_q <= ev_d;
            if (wr_en && hit(OFS_MASK))          mask_q <= bus_wdata[NUM_EV-1:0];
            else if (wr_en && hit(OFS_MASK_SET)) mask_q <= mask_q | bus_wdata[NUM_EV-1:0];
            else if (wr_en && hit(OFS_MASK_CLR)) mask_q <= mask_q & ~bus_wdata[NUM_EV-1:0];
            errsrc_q <= (errsrc_q & ~((wr_en && hit(OFS_ERRSRC)) ?
                                      bus_wdata[ERRSRC_W-1:0] : '0))
                      | (line_break ? ERRSRC_W'(3) : '0);
            if (wr_en && hit(OFS_BAUD)) baud_q <= bus_wdata;
        end
    end

    generate
        for (genvar i = 0; i < NUM_PINSEL; i++) begin : g_pin
            always_ff @(posedge clk) begin
                if (!rst_n)                                    pinsel_q[i] <= '1;
                else if (wr_en && hit(OFS_PIN_BASE + 4*i))     pinsel_q[i] <= bus_wdata;
            end
        end
    endgenerate

    always_comb begin
        rd_mux = '0;
        if (hit(OFS_EV_BASE + 4*EV_RXRDY)) rd_mux = BUS_W'(ev_q[EV_RXRDY]);
        if (hit(OFS_EV_BASE + 4*EV_TXRDY)) rd_mux = BUS_W'(ev_q[EV_TXRDY]);
        if (hit(OFS_EV_BASE + 4*EV_ERR))   rd_mux = BUS_W'(ev_q[EV_ERR]);
        if (hit(OFS_EV_BASE + 4*EV_RXTMO)) rd_mux = BUS_W'(ev_q[EV_RXTMO]);
        if (hit(OFS_MASK) || hit(OFS_MASK_SET) || hit(OFS_MASK_CLR)) rd_mux = BUS_W'(mask_q);
        if (hit(OFS_ERRSRC)) rd_mux = BUS_W'(errsrc_q);
        if (hit(OFS_ENABLE)) rd_mux = BUS_W'(ENABLE_KEY);
        if (hit(OFS_RXD))    rd_mux = BUS_W'(rx_head);
        if (hit(OFS_TXD))    rd_mux = BUS_W'(tx_data);
        if (hit(OFS_BAUD))   rd_mux = baud_q;
        for (int i = 0; i < NUM_PINSEL; i++)
            if (hit(OFS_PIN_BASE + 4*i)) rd_mux = pinsel_q[i];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (rd_any) bus_rdata <= on ? rd_mux : '0;
    end

    assert_dark_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_any && !on) |=> bus_rdata == '0);
    assert_dark_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && !on && hit(OFS_MASK_SET)) |=> $stable(mask_q));
    assert_shutdown_R3: assert property (@(posedge clk) disable iff (!rst_n)
        go_off |=> (!on && !rx_ready && ev_q[EV_RXTMO]));
    assert_break_R5: assert property (@(posedge clk) disable iff (!rst_n)
        line_break |=> (ev_q[EV_ERR] && errsrc_q[1:0] == 2'b11));
    assert_mask_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq);
    assert_rdy_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_ready) |=> ev_q[EV_RXRDY]);

endmodule

// File: tb/sim_uart_evt_ctrl.sv
module sim_uart_evt_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  tx_data;
    logic        tx_valid;
    logic        tx_ready = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_valid = 1'b0;
    logic        rx_ready;
    logic        line_break = 1'b0;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] q[$];

    localparam logic [7:0] A_STRX = 8'h00, A_SPRX = 8'h04, A_STTX = 8'h08, A_SPTX = 8'h0C,
        A_SUSP = 8'h10, A_EVRX = 8'h20, A_EVTX = 8'h24, A_EVER = 8'h28, A_EVTO = 8'h2C,
        A_MSK = 8'h40, A_MSET = 8'h44, A_MCLR = 8'h48, A_ESRC = 8'h50, A_ENA = 8'h54,
        A_RXD = 8'h60, A_TXD = 8'h64, A_PIN = 8'h70, A_BAUD = 8'h80;

    uart_evt_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .line_break(line_break), .irq(irq)
    );

    always #2 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(tag, d, exp);
    endtask

    task automatic push(input logic [7:0] b, output logic acc);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = b;
        acc = rx_ready;
        @(negedge clk);
        rx_valid = 1'b0;
        if (acc) q.push_back(b);
    endtask

    task automatic tx_take();
        @(negedge clk); tx_ready = 1'b1;
        @(negedge clk); tx_ready = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic acc;
        logic [31:0] exp_m;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 irq", irq, 0);
        chk("R11 tx_valid", tx_valid, 0);
        chk("R11 rx_ready", rx_ready, 0);

        // disabled: reads zero, writes ignored
        rd_chk("R2 read baud off", A_BAUD, 0);
        wr(A_MSK, 32'hF);
        wr(A_STRX, 1);
        wr(A_ENA, 5);
        rd_chk("R3 key 5 ignored", A_BAUD, 0);
        wr(A_ENA, 4);
        rd_chk("R11 baud", A_BAUD, 32'h0400_0000);
        for (int i = 0; i < 4; i++) rd_chk("R11 pinsel", A_PIN + 8'(4*i), 32'hFFFF_FFFF);
        rd_chk("R2 mask write ignored", A_MSK, 0);
        chk("R2 start ignored", rx_ready, 0);
        rd_chk("R3 enable readback", A_ENA, 4);

        // mask sweep
        for (int v = 0; v < 16; v++) begin
            wr(A_MSK, v);
            rd_chk("R4 mask", A_MSK, v);
            rd_chk("R4 mask via set", A_MSET, v);
            rd_chk("R4 mask via clr", A_MCLR, v);
        end
        wr(A_MSK, 0);
        exp_m = 0;
        for (int v = 0; v < 16; v++) begin
            wr(A_MSET, v);
            exp_m = exp_m | v;
            wr(A_MCLR, (v * 5) & 15);
            exp_m = exp_m & ~((v * 5) & 15) & 32'hF;
            rd_chk("R4 set/clr", A_MSK, exp_m);
        end

        // interrupt truth table
        for (int e = 0; e < 8; e++) begin
            wr(A_EVTX, e & 1);
            wr(A_EVER, (e >> 1) & 1);
            wr(A_EVTO, (e >> 2) & 1);
            for (int m = 0; m < 16; m++) begin
                wr(A_MSK, m);
                chk("R1 irq", irq, |((e << 1) & m));
            end
        end
        rd_chk("R12 tmo written", A_EVTO, 1);
        wr(A_EVTX, 0); wr(A_EVER, 0); wr(A_EVTO, 0); wr(A_MSK, 0);
        rd_chk("R12 tmo cleared", A_EVTO, 0);

        // start tasks
        wr(A_STRX, 2);
        chk("R8 start rx value 2", rx_ready, 0);
        wr(A_STRX, 1);
        chk("R8 start rx", rx_ready, 1);
        wr(A_STTX, 3);
        wr(A_TXD, 8'h11);
        chk("R8 start tx value 3", tx_valid, 0);
        wr(A_STTX, 1);

        // fill the queue
        for (int i = 0; i < 7; i++) begin
            push(8'h40 + 8'(i), acc);
            chk("R10 accept", acc, i < 6);
        end
        rd_chk("R10 rx event", A_EVRX, 1);
        wr(A_EVRX, 5);
        rd_chk("R10 nonzero no clear", A_EVRX, 1);
        wr(A_MSK, 1);
        chk("R1 rx irq", irq, 1);
        wr(A_EVRX, 0);
        rd_chk("R10 zero clears", A_EVRX, 0);
        wr(A_MSK, 0);

        // drain with re-raise
        for (int i = 0; i < 6; i++) begin
            rd_chk("R9 pop order", A_RXD, q.pop_front());
            rd_chk("R9 re-raise", A_EVRX, q.size() > 0);
            wr(A_EVRX, 0);
        end

        // wrap-around rounds
        for (int r = 0; r < 5; r++) begin
            for (int i = 0; i < r + 2; i++) begin
                push(8'(r * 16 + i), acc);
                chk("R10 wrap accept", acc, 1);
            end
            while (q.size() > 0) rd_chk("R9 wrap order", A_RXD, q.pop_front());
        end
        wr(A_EVRX, 0);

        // stop with data held
        push(8'hA1, acc); push(8'hA2, acc);
        wr(A_SPRX, 1);
        chk("R7 stop rx", rx_ready, 0);
        rd_chk("R7 stop sets tmo", A_EVTO, 1);
        rd_chk("R9 halted head", A_RXD, 8'hA1);
        rd_chk("R9 halted no advance", A_RXD, 8'hA1);
        push(8'hEE, acc);
        chk("R10 halted refuse", acc, 0);
        wr(A_STRX, 1);
        rd_chk("R9 resume pop", A_RXD, q.pop_front());
        rd_chk("R9 resume pop", A_RXD, q.pop_front());
        wr(A_EVTO, 0); wr(A_EVRX, 0);

        // transmit
        wr(A_TXD, 8'hA5);
        chk("R6 valid", tx_valid, 1);
        chk("R6 data", tx_data, 8'hA5);
        wr(A_TXD, 8'h3C);
        chk("R6 pending blocks", tx_data, 8'hA5);
        rd_chk("R6 txrdy before", A_EVTX, 0);
        tx_take();
        chk("R6 valid drops", tx_valid, 0);
        rd_chk("R6 txrdy set", A_EVTX, 1);
        wr(A_MSK, 2);
        chk("R1 tx irq", irq, 1);
        wr(A_MSK, 0);
        wr(A_TXD, 8'h5A);
        chk("R6 second byte", tx_data, 8'h5A);
        tx_take();

        // stop-tx and suspend
        wr(A_SPTX, 1);
        wr(A_TXD, 8'h77);
        chk("R7 stop tx", tx_valid, 0);
        chk("R7 rx untouched", rx_ready, 1);
        rd_chk("R7 stop tx no tmo", A_EVTO, 0);
        wr(A_STTX, 1);
        wr(A_SUSP, 1);
        chk("R7 suspend rx", rx_ready, 0);
        rd_chk("R7 suspend tmo", A_EVTO, 1);
        wr(A_TXD, 8'h66);
        chk("R7 suspend tx", tx_valid, 0);

        // error source
        @(negedge clk); line_break = 1'b1;
        @(negedge clk); line_break = 1'b0;
        rd_chk("R5 errsrc", A_ESRC, 3);
        rd_chk("R5 err event", A_EVER, 1);
        wr(A_ESRC, 1);
        rd_chk("R5 w1c bit0", A_ESRC, 2);
        wr(A_ESRC, 2);
        rd_chk("R5 w1c bit1", A_ESRC, 0);
        wr(A_EVER, 0);
        rd_chk("R12 err cleared", A_EVER, 0);
        wr(A_EVER, 9);
        rd_chk("R12 err set", A_EVER, 1);
        wr(A_EVER, 0);

        // disable
        wr(A_STRX, 1); wr(A_STTX, 1); wr(A_EVTO, 0); wr(A_MSK, 8);
        chk("R1 quiet", irq, 0);
        wr(A_ENA, 0);
        chk("R3 disable tmo irq", irq, 1);
        chk("R3 disable rx", rx_ready, 0);
        rd_chk("R2 read off", A_MSK, 0);
        wr(A_STTX, 1);
        wr(A_ENA, 4);
        wr(A_TXD, 8'h12);
        chk("R3 tx stopped", tx_valid, 0);
        rd_chk("R3 tmo kept", A_EVTO, 1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule